// File: doc/BRIEF.md
# Integrity Violation Observation Scan Cell

This cell sits at the receiving end of an on-chip interconnect. It latches evidence of signal-integrity trouble on that wire into the boundary-scan chain. Two external detectors drive it. The noise flag reports overshoot or ringing, and the skew flag reports a late transition. Both flags are treated as asynchronous and pass through a synchronizer. Each then sets its own sticky violation bit, but only while the detector enable is held high by the pattern-generation instruction.

During a later observation pass, the test controller raises the observe mode and picks one violation bit with the noise/skew select. A capture clock copies that bit into the cell's scan flop, and shift cycles move it on toward TDO. With observe mode low, the cell acts like an ordinary boundary cell: capture samples the pin value. In every mode the functional signal passes from the wire to the core unchanged.

Top module: `integ_obs_cell`

## Requirements
- R1: After reset both violation bits and the scan flop are 0, so `scan_out` reads 0.
- R2: `pin_out` always equals `core_in`, whatever the mode and scan controls.
- R3: A noise flag pulse of at least one clock while `det_en`=1 sets the noise violation bit within three clocks. A capture with `obs_mode`=1 and `sel_noise`=1 then puts that bit on `scan_out` after the capture edge.
- R4: A skew flag pulse of at least one clock while `det_en`=1 sets the skew violation bit within three clocks. A capture with `obs_mode`=1 and `sel_noise`=0 then puts that bit on `scan_out`. Each select reads only its own bit.
- R5: Flag pulses that arrive while `det_en`=0 are ignored, and the violation bits keep their value.
- R6: A violation bit, once set, stays set after its flag falls, for any number of clocks, until a clear or a reset.
- R7: `flag_clr`=1 clears both violation bits at the next edge. A set arriving from the synchronizer in that same cycle loses to the clear.
- R8: A capture with `obs_mode`=0 loads `core_in` into the scan flop.
- R9: With `shift_dr`=1 the scan flop loads `scan_in` at each edge, even when `capture_dr` is also 1.
- R10: With `capture_dr`=0 and `shift_dr`=0 the scan flop, and so `scan_out`, holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_in | input | 1 | Functional signal arriving on the interconnect |
| pin_out | output | 1 | Functional signal delivered to the core |
| noise_flag | input | 1 | Asynchronous overshoot/ringing detector flag |
| skew_flag | input | 1 | Asynchronous late-transition detector flag |
| det_en | input | 1 | Detector enable; violation bits can set only while 1 |
| flag_clr | input | 1 | Clears both violation bits |
| sel_noise | input | 1 | 1 selects the noise bit, 0 the skew bit, for capture |
| obs_mode | input | 1 | 1 captures a violation bit, 0 captures the pin value |
| capture_dr | input | 1 | Capture strobe for the scan flop |
| shift_dr | input | 1 | Shift enable; scan flop takes `scan_in` |
| scan_in | input | 1 | Serial data from the previous cell |
| scan_out | output | 1 | Serial data to the next cell or TDO |

## Verification
Two events can land in the same cycle: a set of a violation bit coming out of the synchronizer, and a clear. The bench times a noise pulse so that its synchronized form reaches the sticky bit on exactly the edge where `flag_clr` is high. It then captures the noise bit and expects 0. A second collision, capture and shift strobes raised together, is judged by checking that `scan_out` follows `scan_in` and not the selected flag.

// File: rtl/integ_obs_cell.sv
module integ_obs_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_in,
  output logic pin_out,
  input  logic noise_flag,
  input  logic skew_flag,
  input  logic det_en,
  input  logic flag_clr,
  input  logic sel_noise,
  input  logic obs_mode,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic scan_in,
  output logic scan_out
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] noise_sync, skew_sync;
  logic         noise_st, skew_st;
  logic         cell_q;
  logic         flag_pick, cap_bit;

  assign pin_out = core_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      noise_sync <= '0;
      skew_sync  <= '0;
    end else begin
      noise_sync <= {noise_sync[TOP-1:0], noise_flag};
      skew_sync  <= {skew_sync[TOP-1:0], skew_flag};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      noise_st <= 1'b0;
      skew_st  <= 1'b0;
    end else if (flag_clr) begin
      noise_st <= 1'b0;
      skew_st  <= 1'b0;
    end else begin
      noise_st <= noise_st | (det_en & noise_sync[TOP]);
      skew_st  <= skew_st  | (det_en & skew_sync[TOP]);
    end

  assign flag_pick = sel_noise ? noise_st : skew_st;
  assign cap_bit   = obs_mode ? flag_pick : core_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cell_q <= 1'b0;
    else if (shift_dr)   cell_q <= scan_in;
    else if (capture_dr) cell_q <= cap_bit;

  assign scan_out = cell_q;

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_st && !flag_clr) |=> noise_st);

  // R5
  gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !flag_clr) |=> ($stable(noise_st) && $stable(skew_st)));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!noise_st && !skew_st));

  // R9
  shift_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_dr |=> (scan_out == $past(scan_in)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_dr && !capture_dr) |=> $stable(scan_out));

  // R3
  noise_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_dr && !shift_dr && obs_mode && sel_noise) |=> (scan_out == $past(noise_st)));

  // R4
  skew_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_dr && !shift_dr && obs_mode && !sel_noise) |=> (scan_out == $past(skew_st)));

endmodule

// File: tb/test_integ_obs_cell.sv
`timescale 1ns/1ps
module test_integ_obs_cell;
  logic clk = 1'b0, rst_n = 1'b0;
  logic core_in = 0, noise_flag = 0, skew_flag = 0, det_en = 0, flag_clr = 0;
  logic sel_noise = 0, obs_mode = 0, capture_dr = 0, shift_dr = 0, scan_in = 0;
  logic pin_out, scan_out;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  integ_obs_cell i_integ_obs_cell (
    .clk(clk), .rst_n(rst_n), .core_in(core_in), .pin_out(pin_out),
    .noise_flag(noise_flag), .skew_flag(skew_flag), .det_en(det_en),
    .flag_clr(flag_clr), .sel_noise(sel_noise), .obs_mode(obs_mode),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .scan_in(scan_in),
    .scan_out(scan_out));

  // {noise pulse, skew pulse, det_en, sel_noise, expected scan bit}
  localparam logic [4:0] VEC [8] = '{
    5'b10111,  // R3 noise seen on noise select
    5'b10100,  // R4 skew select ignores noise bit
    5'b01101,  // R4 skew seen on skew select
    5'b01110,  // R3 noise select ignores skew bit
    5'b11111,  // R3 both set
    5'b11101,  // R4 both set
    5'b11010,  // R5 disabled, noise select
    5'b11000   // R5 disabled, skew select
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic pulse(input logic nz, input logic sk);
    noise_flag = nz; skew_flag = sk; step();
    noise_flag = 0;  skew_flag = 0;  step(3);
  endtask

  task automatic capture(input logic obs, input logic sel);
    obs_mode = obs; sel_noise = sel; capture_dr = 1; step();
    capture_dr = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 reset scan_out", scan_out, 1'b0);
    rst_n = 1; step();
    capture(1, 1); chk("R1 reset noise bit", scan_out, 1'b0);
    capture(1, 0); chk("R1 reset skew bit", scan_out, 1'b0);

    core_in = 1; #1 chk("R2 pass high", pin_out, 1'b1);
    obs_mode = 1; shift_dr = 1; core_in = 0; #1 chk("R2 pass low in scan", pin_out, 1'b0);
    shift_dr = 0; obs_mode = 0; step();

    foreach (VEC[k]) begin
      clear();
      det_en = VEC[k][2];
      pulse(VEC[k][4], VEC[k][3]);
      det_en = 0;
      capture(1, VEC[k][1]);
      chk($sformatf("R3/R4/R5 vector %0d", k), scan_out, VEC[k][0]);
    end

    clear(); det_en = 1; pulse(1, 0); det_en = 0;
    step(20);
    capture(1, 1); chk("R6 noise bit sticky", scan_out, 1'b1);
    capture(1, 1); chk("R6 still set after re-capture", scan_out, 1'b1);
    clear(); capture(1, 1); chk("R7 clear drops noise", scan_out, 1'b0);

    det_en = 1; pulse(0, 1); capture(1, 0); chk("R6 skew bit set", scan_out, 1'b1);
    clear(); capture(1, 0); chk("R7 clear drops skew", scan_out, 1'b0);

    noise_flag = 1; step();
    noise_flag = 0; step();
    flag_clr = 1; step();
    flag_clr = 0; step(3);
    det_en = 0;
    capture(1, 1); chk("R7 clear beats same-cycle set", scan_out, 1'b0);

    core_in = 1; capture(0, 1); chk("R8 normal capture high", scan_out, 1'b1);
    core_in = 0; capture(0, 1); chk("R8 normal capture low", scan_out, 1'b0);

    shift_dr = 1;
    scan_in = 1; step(); chk("R9 shift 1", scan_out, 1'b1);
    scan_in = 0; step(); chk("R9 shift 0", scan_out, 1'b0);
    scan_in = 1; step(); chk("R9 shift 1 again", scan_out, 1'b1);
    shift_dr = 0;

    det_en = 1; pulse(1, 0); det_en = 0;
    scan_in = 0; obs_mode = 1; sel_noise = 1; shift_dr = 1; capture_dr = 1; step();
    shift_dr = 0; capture_dr = 0;
    chk("R9 shift beats capture", scan_out, 1'b0);

    step(5); chk("R10 idle hold low", scan_out, 1'b0);
    capture(1, 1); step(5); chk("R10 idle hold high", scan_out, 1'b1);

    rst_n = 0; step(); rst_n = 1; step();
    capture(1, 1); chk("R1 reset clears noise bit", scan_out, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule